// File: doc/BRIEF.md
# Charge Command Watchdog Timer

This block watches the host's register-write stream to a battery charger. The host is expected to refresh the charge-current or charge-voltage setting at regular intervals. If it stops doing so for longer than a chosen timeout, the block raises a converter-suspend flag. That flag gates both charging and boost operation of the power converter.

Expiry never clears or alters any register. The converter stays suspended until the host makes a qualifying write, and then it resumes at once. The block holds its own copy of the 2-bit timeout-select field, taken from writes to the options register. Timeouts are counted in ticks, and the clock cycles per tick are a parameter. A tick is one second in the chip and can be a few cycles in simulation.

Top module: `charge_cmd_watchdog`

## Requirements
- R1: After reset the suspend output is 0 and the timeout-select field is code 11, so the first expiry comes 175 ticks after reset is released.
- R2: Timeout-select codes decode as 01 = 5 ticks, 10 = 88 ticks and 11 = 175 ticks. The suspend output rises exactly limit × TICK_CYCLES clock cycles after the cycle in which the timer was last restarted.
- R3: A write to address 0x14 (charge current) or 0x15 (charge voltage) restarts the timer from zero.
- R4: The timeout-select field is bits [14:13] of a write to address 0x12. A write there that changes the field restarts the timer under the new code. A write there that leaves the field unchanged restarts nothing.
- R5: Once asserted, the suspend output stays at 1 until a restarting event occurs.
- R6: A write to 0x14 or 0x15 while suspended clears the suspend output on the next clock edge.
- R7: Writes to any other address neither restart the timer nor clear the suspend output.
- R8: Code 00 disables the watchdog. Selecting it clears any pending suspend, and while it is selected the suspend output stays 0 whatever the host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Data of the write |
| conv_suspend | output | 1 | 1 = converter suspended (charge and boost off) |

## Verification
The assertions assume that each host write is a single-cycle strobe with a stable address and data in that cycle. They also assume that reset is held for at least one edge before any write. The bench drives every write for exactly one cycle, between falling edges. It never overlaps two writes, and it spaces restarting events so that each expected expiry cycle can be computed from the last restart alone.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'b00,
        WD_SHORT = 2'b01,
        WD_MID   = 2'b10,
        WD_LONG  = 2'b11
    } wd_sel_e;

    // Decoded control for one cycle of host traffic
    typedef struct packed {
        logic    kick;      // restart timer, clear suspend
        logic    sel_load;  // timeout-select field changes
        wd_sel_e sel_new;   // value to load
    } wd_ctl_t;

    function automatic int unsigned wd_limit(wd_sel_e s, int unsigned l_short,
                                             int unsigned l_mid, int unsigned l_long);
        case (s)
            WD_SHORT: return l_short;
            WD_MID:   return l_mid;
            WD_LONG:  return l_long;
            default:  return 0;
        endcase
    endfunction

    function automatic int unsigned wd_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned wd_width(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/wd_cmd_decode.sv
module wd_cmd_decode
    import wd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter logic [ADDR_W-1:0] CURR_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] VOLT_ADDR = 8'h15,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 8'h12,
    parameter int unsigned SEL_LSB = 13
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wd_sel_e           sel_cur,
    output wd_ctl_t           ctl
);
    wd_sel_e sel_field;
    logic    cmd_hit;
    logic    opt_hit;
    logic    sel_change;
    logic    unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        sel_field  = wd_sel_e'(wr_data[SEL_LSB +: 2]);
        cmd_hit    = wr_en && ((wr_addr == CURR_ADDR) || (wr_addr == VOLT_ADDR));
        opt_hit    = wr_en && (wr_addr == OPT_ADDR);
        sel_change = opt_hit && (sel_field != sel_cur);
        ctl.kick     = cmd_hit || sel_change;
        ctl.sel_load = sel_change;
        ctl.sel_new  = sel_field;
    end
endmodule

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
    parameter int unsigned TICK_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/wd_expiry.sv
module wd_expiry #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hold_off,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             suspend,
    output logic [CNT_W-1:0] count
);
    logic             susp_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || hold_off) begin
            cnt_q  <= '0;
            susp_q <= 1'b0;
        end else if (tick && !susp_q) begin
            if (cnt_q == limit - CNT_W'(1)) begin
                cnt_q  <= limit;
                susp_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign suspend = susp_q;
    assign count   = cnt_q;
endmodule

// File: rtl/charge_cmd_watchdog.sv
module charge_cmd_watchdog
    import wd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CURR_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] VOLT_ADDR = 8'h15,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 8'h12,
    parameter int unsigned SEL_LSB     = 13,
    parameter int unsigned TICK_CYCLES = 100_000_000,
    parameter int unsigned LIM_SHORT   = 5,
    parameter int unsigned LIM_MID     = 88,
    parameter int unsigned LIM_LONG    = 175
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              conv_suspend
);
    localparam int unsigned MAX_LIM = wd_max3(LIM_SHORT, LIM_MID, LIM_LONG);
    localparam int unsigned CNT_W   = wd_width(MAX_LIM);

    wd_ctl_t          ctl;
    wd_sel_e          sel_q;
    logic             tick;
    logic             run;
    logic             suspend;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;

    wd_cmd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CURR_ADDR(CURR_ADDR), .VOLT_ADDR(VOLT_ADDR), .OPT_ADDR(OPT_ADDR),
        .SEL_LSB(SEL_LSB)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_cur(sel_q), .ctl(ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= WD_LONG;
        end else if (ctl.sel_load) begin
            sel_q <= ctl.sel_new;
        end
    end

    assign limit = CNT_W'(wd_limit(sel_q, LIM_SHORT, LIM_MID, LIM_LONG));
    assign run   = (sel_q != WD_OFF) && !suspend;

    wd_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .clear(ctl.kick), .run(run), .tick(tick)
    );

    wd_expiry #(.CNT_W(CNT_W)) u_exp (
        .clk(clk), .rst(rst), .clear(ctl.kick),
        .hold_off(sel_q == WD_OFF), .tick(tick), .limit(limit),
        .suspend(suspend), .count(count)
    );

    assign conv_suspend = suspend;
endmodule

// File: rtl/charge_wd_checker.sv
module charge_wd_checker
    import wd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter logic [ADDR_W-1:0] CURR_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] VOLT_ADDR = 8'h15,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 8'h12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input wd_sel_e           sel_q,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  limit,
    input logic              conv_suspend
);
    logic cmd_wr;
    logic other_wr;
    assign cmd_wr   = wr_en && ((wr_addr == CURR_ADDR) || (wr_addr == VOLT_ADDR));
    assign other_wr = wr_en && !cmd_wr && (wr_addr != OPT_ADDR);

    p_cmd_clears_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !conv_suspend);

    p_no_rise_after_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_suspend) |-> !$past(cmd_wr));

    p_other_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (other_wr && conv_suspend) |=> conv_suspend);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_suspend && !wr_en) |=> conv_suspend);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_q == WD_OFF) |-> (!conv_suspend && count == '0));

    p_full_at_expiry_r2: assert property (@(posedge clk) disable iff (rst)
        conv_suspend |-> (count == limit));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_q != WD_OFF) |-> (count <= limit));
endmodule

bind charge_cmd_watchdog charge_wd_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CURR_ADDR(CURR_ADDR), .VOLT_ADDR(VOLT_ADDR), .OPT_ADDR(OPT_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .sel_q(sel_q), .count(count), .limit(limit), .conv_suspend(conv_suspend)
);

// File: tb/sim_charge_cmd_watchdog.sv
module sim_charge_cmd_watchdog;
    localparam int TICK = 4;
    localparam int N_SHORT = 5, N_MID = 88, N_LONG = 175;

    typedef struct {
        int    cyc;
        bit    val;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        conv_suspend;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    charge_cmd_watchdog #(
        .TICK_CYCLES(TICK), .LIM_SHORT(N_SHORT), .LIM_MID(N_MID), .LIM_LONG(N_LONG)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .conv_suspend(conv_suspend)
    );

    // scoreboard monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.cyc < cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed (now %0d), expected %0b",
                         e.req, e.cyc, cyc, e.val);
            end else if (conv_suspend !== e.val) begin
                n_fail++;
                $display("FAIL %s: cycle %0d conv_suspend=%0b expected %0b",
                         e.req, cyc, conv_suspend, e.val);
            end
        end
    end

    task automatic expect_at(input int c, input bit v, input string r);
        exp_t e;
        e.cyc = c; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // drives one write; k returns the cycle count after the capturing edge
    task automatic wr(input int at, input logic [7:0] a, input logic [15:0] d, output int k);
        wait_until(at);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        k = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            report();
        end
    end

    initial begin
        int k, k2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        k = cyc;                                   // last reset edge arms the timer
        expect_at(k + 1, 1'b0, "R1 reset state");
        expect_at(k + N_LONG*TICK - 1, 1'b0, "R1 default 175 ticks, before");
        expect_at(k + N_LONG*TICK, 1'b1, "R1 default 175 ticks, expiry");

        // other address while suspended (R7)
        wr(k + N_LONG*TICK + 2, 8'h20, 16'hFFFF, k2);
        expect_at(k2, 1'b1, "R7 other addr keeps suspend");
        expect_at(k2 + 3, 1'b1, "R7 other addr keeps suspend later");
        // option write with unchanged field 11 (R4)
        wr(k2 + 5, 8'h12, 16'h6001, k);
        expect_at(k, 1'b1, "R4 unchanged field no restart");

        // charge-current write clears (R6), then select code 01 (R2)
        wr(k + 5, 8'h14, 16'h0400, k);
        expect_at(k, 1'b0, "R6 current write clears suspend");
        wr(k + 100, 8'h12, 16'h2000, k);
        expect_at(k + N_SHORT*TICK - 1, 1'b0, "R2 code 01 before");
        expect_at(k + N_SHORT*TICK, 1'b1, "R2 code 01 expiry");

        // voltage write clears, second one restarts (R3)
        wr(k + N_SHORT*TICK + 5, 8'h15, 16'h3000, k);
        expect_at(k, 1'b0, "R6 voltage write clears suspend");
        wr(k + 10, 8'h15, 16'h3000, k2);
        expect_at(k + N_SHORT*TICK, 1'b0, "R3 restart moves expiry");
        expect_at(k2 + N_SHORT*TICK - 1, 1'b0, "R3 restarted before");
        expect_at(k2 + N_SHORT*TICK, 1'b1, "R3 restarted expiry");

        // field change to 10 clears and restarts (R4, R2)
        wr(k2 + N_SHORT*TICK + 3, 8'h12, 16'h4000, k);
        expect_at(k, 1'b0, "R4 field change clears");
        expect_at(k + N_MID*TICK - 1, 1'b0, "R2 code 10 before");
        expect_at(k + N_MID*TICK, 1'b1, "R2 code 10 expiry");

        // other addresses while counting do not restart (R7)
        wr(k + N_MID*TICK + 2, 8'h14, 16'h0100, k);
        wr(k + 10, 8'h16, 16'h0000, k2);
        wr(k + 40, 8'h3F, 16'h1000, k2);
        expect_at(k + N_MID*TICK - 1, 1'b0, "R7 other addr no restart, before");
        expect_at(k + N_MID*TICK, 1'b1, "R7 other addr no restart, expiry");

        // code 00 disables (R8)
        wr(k + N_MID*TICK + 2, 8'h12, 16'h0000, k);
        expect_at(k, 1'b0, "R8 disable clears suspend");
        wr(k + 20, 8'h14, 16'h0100, k2);
        expect_at(k + 1000, 1'b0, "R8 stays clear while disabled");

        // back to code 11; unchanged-field write mid-way does not restart (R4)
        wr(k + 1002, 8'h12, 16'h6000, k);
        wr(k + 50, 8'h12, 16'h7FFF, k2);
        expect_at(k + N_LONG*TICK - 1, 1'b0, "R4 code 11 re-enabled, before");
        expect_at(k + N_LONG*TICK, 1'b1, "R4 unchanged write kept expiry");

        wait_until(k + N_LONG*TICK + 3);
        done = 1'b1;
        report();
    end
endmodule